// File: doc/BRIEF.md
# Floating-Point Invalid-Operation Detector

This block inspects the operands of a double-precision floating-point operation before the operation runs, and reports which invalid-operation conditions the operands trigger. It is purely combinational. An operation code selects which checks apply. The result is a 32-bit word with cause bits placed in the floating-point status word layout, so the caller can OR it straight into its status register.

One shared checker serves every operation. A per-operation enable set switches each condition test on or off. For subtraction, the sign test of the infinity-minus-infinity check is inverted. The block computes no result and does no rounding. It does not look at overflow, underflow or inexact.

Operation codes on `op_i`: 0 add, 1 subtract, 2 multiply, 3 divide, 4 multiply-add, 5 multiply-subtract, 6 negated multiply-add, 7 negated multiply-subtract, 8 square root. Codes 9 to 15 are unused.

Top module: `fp_invalid_detect`

## Requirements
- R1: Any condition bit that is set in `flags_o` also sets the summary bit at bit 31. When no condition bit is set, bit 31 is clear.
- R2: For codes 0 to 3, signaling-NaN bit 24 is set when `a_i` or `b_i` is a NaN whose quiet bit is 0. A NaN has exponent bits 62..52 all ones and a nonzero fraction in bits 51..0; the quiet bit is bit 51. A quiet NaN never sets bit 24.
- R3: For add, infinity-difference bit 23 is set when both `a_i` and `b_i` are infinite with opposite signs.
- R4: For subtract, bit 23 is set when both `a_i` and `b_i` are infinite with the same sign.
- R5: For multiply, zero-times-infinity bit 20 is set when one of `a_i`, `b_i` is a zero of either sign and the other is infinite, in either order.
- R6: For divide, infinity-over-infinity bit 22 is set when both `a_i` and `b_i` are infinite.
- R7: For divide, zero-over-zero bit 21 is set when both `a_i` and `b_i` are zero of either sign. A denormal is not zero.
- R8: For codes 4 to 7, bit 24 is set when any of `a_i`, `b_i`, `c_i` is a signaling NaN. Bit 20 is set on a zero-times-infinity pair in `a_i` and `b_i`. `c_i` takes no part in the bit 20 test.
- R9: For square root, negative-operand bit 9 is set when `a_i` has its sign bit set and is neither a zero nor a NaN. Negative zero gives all-zero flags.
- R10: For square root with a NaN in `a_i`, only bit 24 can be set, and only when that NaN is signaling. A quiet NaN of either sign gives all-zero flags.
- R11: Codes 9 to 15 give all-zero flags. An operand that an operation does not use has no effect: `b_i` and `c_i` for square root, and `c_i` for codes 0 to 3.
- R12: No bit of `flags_o` other than 31, 24, 23, 22, 21, 20 and 9 is ever set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 64 | First operand (the only operand for square root) |
| b_i | input | 64 | Second operand |
| c_i | input | 64 | Addend for the multiply-add family |
| flags_o | output | 32 | Invalid-operation cause bits and summary bit |

## Verification
The bound assertions check on every evaluation that only the defined bit positions are used, that the summary bit follows any cause, that unused codes and square roots of signed zeros stay silent, and that opposite infinities under add and a signaling addend under multiply-add are flagged. Other behaviours can only be shown by the bench scenarios. These are the sign inversion for subtract, the symmetry of the zero-times-infinity test, the split between denormals and zeros, and the independence from unused operands. The bench sweeps every operation code over a grid of special values and compares each result with a behavioural model.

// File: rtl/fp_invalid_detect.sv
module fp_invalid_detect #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int OP_W   = 4
) (
  input  logic [OP_W-1:0]         op_i,
  input  logic [EXP_W+FRAC_W:0]   a_i,
  input  logic [EXP_W+FRAC_W:0]   b_i,
  input  logic [EXP_W+FRAC_W:0]   c_i,
  output logic [31:0]             flags_o
);
  localparam int W = EXP_W + FRAC_W + 1;

  localparam logic [OP_W-1:0] OP_ADD   = OP_W'(0);
  localparam logic [OP_W-1:0] OP_SUB   = OP_W'(1);
  localparam logic [OP_W-1:0] OP_MUL   = OP_W'(2);
  localparam logic [OP_W-1:0] OP_DIV   = OP_W'(3);
  localparam logic [OP_W-1:0] OP_FMA   = OP_W'(4);
  localparam logic [OP_W-1:0] OP_FMS   = OP_W'(5);
  localparam logic [OP_W-1:0] OP_NFMA  = OP_W'(6);
  localparam logic [OP_W-1:0] OP_NFMS  = OP_W'(7);
  localparam logic [OP_W-1:0] OP_SQRT  = OP_W'(8);

  localparam int BIT_SUM  = 31;
  localparam int BIT_SNAN = 24;
  localparam int BIT_ISI  = 23;
  localparam int BIT_IDI  = 22;
  localparam int BIT_ZDZ  = 21;
  localparam int BIT_IMZ  = 20;
  localparam int BIT_SQRT = 9;

  logic [W-1:0] opnd [3];
  logic [2:0]   is_nan, is_snan, is_inf, is_zero, sgn;

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;
  assign opnd[2] = c_i;

  for (genvar g = 0; g < 3; g++) begin : g_cls
    logic exp_ones, frac_nz;
    assign exp_ones   = &opnd[g][W-2 -: EXP_W];
    assign frac_nz    = |opnd[g][FRAC_W-1:0];
    assign is_nan[g]  = exp_ones & frac_nz;
    assign is_snan[g] = exp_ones & frac_nz & ~opnd[g][FRAC_W-1];
    assign is_inf[g]  = exp_ones & ~frac_nz;
    assign is_zero[g] = ~|opnd[g][W-2:0];
    assign sgn[g]     = opnd[g][W-1];
  end

  typedef struct packed {
    logic [2:0] sn;
    logic       isi;
    logic       isi_same;
    logic       idi;
    logic       zdz;
    logic       imz;
    logic       sqrt;
  } en_t;

  en_t en;

  always_comb begin
    en = '0;
    unique case (op_i)
      OP_ADD:  begin en.sn = 3'b011; en.isi = 1'b1; end
      OP_SUB:  begin en.sn = 3'b011; en.isi = 1'b1; en.isi_same = 1'b1; end
      OP_MUL:  begin en.sn = 3'b011; en.imz = 1'b1; end
      OP_DIV:  begin en.sn = 3'b011; en.idi = 1'b1; en.zdz = 1'b1; end
      OP_FMA, OP_FMS, OP_NFMA, OP_NFMS:
               begin en.sn = 3'b111; en.imz = 1'b1; end
      OP_SQRT: begin en.sn = 3'b001; en.sqrt = 1'b1; end
      default: en = '0;
    endcase
  end

  logic hit_snan, hit_isi, hit_idi, hit_zdz, hit_imz, hit_sqrt;

  assign hit_snan = |(en.sn & is_snan);
  assign hit_isi  = en.isi & is_inf[0] & is_inf[1] & ((sgn[0] ^ sgn[1]) ^ en.isi_same);
  assign hit_idi  = en.idi & is_inf[0] & is_inf[1];
  assign hit_zdz  = en.zdz & is_zero[0] & is_zero[1];
  assign hit_imz  = en.imz & ((is_zero[0] & is_inf[1]) | (is_inf[0] & is_zero[1]));
  assign hit_sqrt = en.sqrt & sgn[0] & ~is_zero[0] & ~is_nan[0];

  always_comb begin
    flags_o           = '0;
    flags_o[BIT_SNAN] = hit_snan;
    flags_o[BIT_ISI]  = hit_isi;
    flags_o[BIT_IDI]  = hit_idi;
    flags_o[BIT_ZDZ]  = hit_zdz;
    flags_o[BIT_IMZ]  = hit_imz;
    flags_o[BIT_SQRT] = hit_sqrt;
    flags_o[BIT_SUM]  = hit_snan | hit_isi | hit_idi | hit_zdz | hit_imz | hit_sqrt;
  end
endmodule

module fp_invalid_detect_chk #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int OP_W   = 4
) (
  input logic [OP_W-1:0]       op_i,
  input logic [EXP_W+FRAC_W:0] a_i,
  input logic [EXP_W+FRAC_W:0] b_i,
  input logic [EXP_W+FRAC_W:0] c_i,
  input logic [31:0]           flags_o
);
  localparam int W = EXP_W + FRAC_W + 1;
  localparam logic [31:0] LEGAL = 32'h81F0_0200;

  function automatic logic inf_f(input logic [W-1:0] x);
    return (&x[W-2 -: EXP_W]) && (x[FRAC_W-1:0] == '0);
  endfunction

  function automatic logic snan_f(input logic [W-1:0] x);
    return (&x[W-2 -: EXP_W]) && (x[FRAC_W-1:0] != '0) && !x[FRAC_W-1];
  endfunction

  always_comb begin
    AST_LEGAL_BITS: assert ((flags_o & ~LEGAL) == '0); // R12
    AST_SUMMARY: assert ((flags_o[30:0] == '0) || flags_o[31]); // R1
    AST_UNUSED_OP: assert (!(op_i > OP_W'(8)) || flags_o == '0); // R11
    AST_SQRT_ZERO: assert (!(op_i == OP_W'(8) && a_i[W-2:0] == '0) || flags_o == '0); // R9
    AST_ADD_ISI: assert (!(op_i == OP_W'(0) && inf_f(a_i) && inf_f(b_i) && a_i[W-1] != b_i[W-1]) || flags_o[23]); // R3
    AST_FMA_SNAN_C: assert (!(op_i >= OP_W'(4) && op_i <= OP_W'(7) && snan_f(c_i)) || flags_o[24]); // R8
  end
endmodule

bind fp_invalid_detect fp_invalid_detect_chk #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .OP_W(OP_W)
) u_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i), .flags_o(flags_o)
);

// File: tb/fp_invalid_detect_bench.sv
module fp_invalid_detect_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [3:0]  op;
  logic [63:0] a, b, c;
  logic [31:0] flags;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  fp_invalid_detect u_fp_invalid_detect (
    .op_i(op), .a_i(a), .b_i(b), .c_i(c), .flags_o(flags)
  );

  localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] P_QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] N_QNAN = 64'hFFF8_0000_0000_0001;
  localparam logic [63:0] P_SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] N_SNAN = 64'hFFF4_0000_0000_0000;
  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] N_VAL  = 64'hC004_0000_0000_0000;
  localparam logic [63:0] P_DEN  = 64'h0000_0000_0000_0001;

  function automatic logic [63:0] pick(input int i);
    case (i)
      0: return P_ZERO;  1: return N_ZERO;  2: return P_INF;   3: return N_INF;
      4: return P_QNAN;  5: return N_QNAN;  6: return P_SNAN;  7: return N_SNAN;
      8: return P_ONE;   9: return N_VAL;   default: return P_DEN;
    endcase
  endfunction

  function automatic bit nan_m(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0;
  endfunction
  function automatic bit snan_m(input logic [63:0] x);
    return nan_m(x) && x[51] == 1'b0;
  endfunction
  function automatic bit inf_m(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] == 0;
  endfunction
  function automatic bit zero_m(input logic [63:0] x);
    return x[62:0] == 0;
  endfunction

  function automatic logic [31:0] model(input int o, input logic [63:0] x, y, z);
    logic [31:0] m = 0;
    if (o <= 3 && (snan_m(x) || snan_m(y))) m[24] = 1;
    if (o >= 4 && o <= 7 && (snan_m(x) || snan_m(y) || snan_m(z))) m[24] = 1;
    if (o == 8 && snan_m(x)) m[24] = 1;
    if (o == 0 && inf_m(x) && inf_m(y) && x[63] != y[63]) m[23] = 1;
    if (o == 1 && inf_m(x) && inf_m(y) && x[63] == y[63]) m[23] = 1;
    if (o == 3 && inf_m(x) && inf_m(y)) m[22] = 1;
    if (o == 3 && zero_m(x) && zero_m(y)) m[21] = 1;
    if ((o == 2 || (o >= 4 && o <= 7)) &&
        ((zero_m(x) && inf_m(y)) || (inf_m(x) && zero_m(y)))) m[20] = 1;
    if (o == 8 && x[63] && !zero_m(x) && !nan_m(x)) m[9] = 1;
    if (m != 0) m[31] = 1;
    return m;
  endfunction

  task automatic run(input string tag, input int o, input logic [63:0] x, y, z);
    logic [31:0] exp;
    @(negedge clk);
    op = 4'(o); a = x; b = y; c = z;
    exp = model(o, x, y, z);
    @(posedge clk); #1;
    n_tests++;
    if (flags !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h c=%h got=%h exp=%h", tag, o, x, y, z, flags, exp);
    end
  endtask

  task automatic want(input string tag, input int o, input logic [63:0] x, y, z,
                      input logic [31:0] exp);
    @(negedge clk);
    op = 4'(o); a = x; b = y; c = z;
    @(posedge clk); #1;
    n_tests++;
    if (flags !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d got=%h exp=%h", tag, o, flags, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired got=%0d exp=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    op = 0; a = 0; b = 0; c = 0;
    want("R11 idle", 0, P_ONE, P_ONE, P_ONE, 32'h0);
    want("R2 snan add", 0, P_SNAN, P_ONE, P_ZERO, 32'h8100_0000);
    want("R2 qnan add", 0, P_QNAN, N_QNAN, P_ZERO, 32'h0);
    want("R3 add opp inf", 0, P_INF, N_INF, P_ZERO, 32'h8080_0000);
    want("R3 add same inf", 0, N_INF, N_INF, P_ZERO, 32'h0);
    want("R4 sub same inf", 1, P_INF, P_INF, P_ZERO, 32'h8080_0000);
    want("R4 sub opp inf", 1, P_INF, N_INF, P_ZERO, 32'h0);
    want("R5 mul 0*inf", 2, N_ZERO, P_INF, P_ZERO, 32'h8010_0000);
    want("R5 mul inf*0", 2, N_INF, P_ZERO, P_ZERO, 32'h8010_0000);
    want("R6 div inf/inf", 3, N_INF, P_INF, P_ZERO, 32'h8040_0000);
    want("R7 div 0/0", 3, N_ZERO, P_ZERO, P_ZERO, 32'h8020_0000);
    want("R7 div den/0", 3, P_DEN, P_ZERO, P_ZERO, 32'h0);
    want("R8 fma snan c", 6, P_ONE, P_ONE, N_SNAN, 32'h8100_0000);
    want("R8 fma imz c", 5, P_ONE, P_ONE, P_INF, 32'h0);
    want("R8 fma imz ab", 7, P_INF, P_ZERO, P_INF, 32'h8010_0000);
    want("R9 sqrt neg", 8, N_VAL, P_ZERO, P_ZERO, 32'h8000_0200);
    want("R9 sqrt -inf", 8, N_INF, P_ZERO, P_ZERO, 32'h8000_0200);
    want("R9 sqrt -0", 8, N_ZERO, P_ZERO, P_ZERO, 32'h0);
    want("R10 sqrt -qnan", 8, N_QNAN, P_ZERO, P_ZERO, 32'h0);
    want("R10 sqrt -snan", 8, N_SNAN, P_ZERO, P_ZERO, 32'h8100_0000);
    want("R11 sqrt b,c unused", 8, P_ONE, P_SNAN, N_SNAN, 32'h0);
    want("R11 div c unused", 3, P_ONE, P_ONE, P_SNAN, 32'h0);
    want("R11 op 9", 9, P_SNAN, P_INF, N_INF, 32'h0);
    want("R11 op 15", 15, P_ZERO, P_ZERO, P_SNAN, 32'h0);
    want("R12 R1 stacked", 3, P_SNAN, P_ZERO, P_ZERO, 32'h8100_0000);
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 11; i++)
        for (int j = 0; j < 11; j++)
          for (int k = 0; k < 11; k += 5)
            run("R1 R12 sweep", o, pick(i), pick(j), pick(k));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule